// File: doc/BRIEF.md
# Two-Step Thermometer ADC Encoder

This block is the digital back end of a 10-bit current-mode converter made of 1024 unit cells. The cells are grouped into 64 coarse groups of 16 fine cells each. The analog side compares each cell's current against a current that is proportional to the peak amplitude. It returns one thermometer vector for the coarse groups and another for the fine cells of one group.

A start strobe launches a conversion. In the coarse step the block reads the 64-bit coarse vector and fixes the six high-order bits. It drives these bits out as a group select, which steers the analog side so that the fine vector belongs to that group. In the fine step it reads the 16-bit fine vector and fixes the four low-order bits. The combined code is then presented with a one-cycle valid strobe.

Each vector is encoded from the position of its topmost set bit. A missing one below the top therefore cannot lower the result. A start pulse always forces the sequencer back to the coarse step, so the sequencer has no state it cannot leave.

Top module: `two_step_therm_enc`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, valid, code and grp_sel are all zero.
- R2: A coarse vector whose ones fill bits 0..k-1 (k from 0 to 63) gives grp_sel = k and code[9:4] = k.
- R3: A coarse vector with all 64 bits set saturates to grp_sel = 63 and code[9:4] = 63.
- R4: A fine vector whose ones fill bits 0..m-1 gives code[3:0] = m for m from 0 to 15. A fully set fine vector gives 15.
- R5: Each vector is encoded as (index of its highest set bit + 1), saturated as in R3 and R4. Zeros below that bit have no effect, and an all-zero vector gives 0.
- R6: Take the clock edge at which start is sampled high as edge 0. The coarse vector is sampled at edge 1 and grp_sel updates there. The fine vector is sampled at edge 2. valid is high for exactly the one cycle that follows edge 2.
- R7: grp_sel and the code bits taken from the coarse vector do not change when the coarse vector moves after edge 1. Once valid has been asserted, code holds its value until the next conversion completes.
- R8: A start pulse sampled during a conversion abandons it. The abandoned conversion produces no valid strobe, and the new conversion completes with the R6 timing counted from the new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches (or relaunches) a conversion |
| coarse_therm | input | 64 | Coarse-group thermometer vector, bit 0 lowest |
| fine_therm | input | 16 | Fine-cell thermometer vector of the selected group |
| grp_sel | output | 6 | Selected coarse group, steers the fine step |
| code | output | 10 | Converted result, group in bits 9:4, fine in bits 3:0 |
| valid | output | 1 | One-cycle strobe marking a fresh code |

## Verification
The case that is hardest to reach from the ports is a restart that lands in the fine step. By then the group select already holds the old group, but no code has been produced yet. The stimulus counts falling edges after a first start and raises start again exactly while the fine vector is due to be sampled. It presents different vectors at that moment. It then confirms that no strobe appears for the abandoned conversion and that the strobe which follows carries the new vectors. A separate test moves the coarse vector after it has been sampled, to show that the result does not follow it.

// File: rtl/tse_pkg.sv
package tse_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COARSE = 2'd1,
    ST_FINE   = 2'd2,
    ST_DONE   = 2'd3
  } tse_state_e;
endpackage

// File: rtl/tse_therm_enc.sv
module tse_therm_enc #(
  parameter int W  = 16,
  localparam int OW = $clog2(W)
) (
  input  logic [W-1:0]  therm,
  output logic [OW-1:0] value
);
  logic [OW:0] top_plus1;

  // highest set bit wins, so bubbles below it are harmless
  always_comb begin
    top_plus1 = '0;
    for (int i = 0; i < W; i++) begin
      if (therm[i]) top_plus1 = (OW+1)'(i + 1);
    end
    if (top_plus1 > (OW+1)'(W - 1)) value = OW'(W - 1);
    else                           value = top_plus1[OW-1:0];
  end
endmodule

// File: rtl/tse_seq.sv
module tse_seq
  import tse_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic in_coarse,
  output logic in_fine,
  output logic in_done
);
  tse_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start) st_d = ST_COARSE;
    else begin
      case (st_q)
        ST_IDLE:   st_d = ST_IDLE;
        ST_COARSE: st_d = ST_FINE;
        ST_FINE:   st_d = ST_DONE;
        ST_DONE:   st_d = ST_IDLE;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign in_coarse = (st_q == ST_COARSE);
  assign in_fine   = (st_q == ST_FINE);
  assign in_done   = (st_q == ST_DONE);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> in_coarse);
  // R6
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_done |=> !in_done);
  // R6
  fine_after_coarse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fine |-> $past(in_coarse));
endmodule

// File: rtl/two_step_therm_enc.sv
module two_step_therm_enc #(
  parameter int COARSE_N = 64,
  parameter int FINE_N   = 16,
  localparam int CB = $clog2(COARSE_N),
  localparam int FB = $clog2(FINE_N),
  localparam int CW = CB + FB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [COARSE_N-1:0] coarse_therm,
  input  logic [FINE_N-1:0]   fine_therm,
  output logic [CB-1:0]       grp_sel,
  output logic [CW-1:0]       code,
  output logic                valid
);
  logic          in_coarse, in_fine, in_done;
  logic [CB-1:0] coarse_val;
  logic [FB-1:0] fine_val;
  logic [CB-1:0] grp_q;
  logic [CW-1:0] code_q;

  tse_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_coarse (in_coarse),
    .in_fine   (in_fine),
    .in_done   (in_done)
  );

  tse_therm_enc #(.W(COARSE_N)) u_coarse_enc (
    .therm (coarse_therm),
    .value (coarse_val)
  );

  tse_therm_enc #(.W(FINE_N)) u_fine_enc (
    .therm (fine_therm),
    .value (fine_val)
  );

  // group select is captured once, in the coarse step
  always_ff @(posedge clk) begin
    if (!rst_n)                 grp_q <= '0;
    else if (in_coarse && !start) grp_q <= coarse_val;
  end

  // code is assembled in the fine step and then held
  always_ff @(posedge clk) begin
    if (!rst_n)                 code_q <= '0;
    else if (in_fine && !start) code_q <= {grp_q, fine_val};
  end

  assign grp_sel = grp_q;
  assign code    = code_q;
  assign valid   = in_done;

  // R2
  code_matches_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> code[CW-1:FB] == grp_sel);
  // R7
  sel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_done |-> $stable(grp_sel));
  // R7
  code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_done && !$past(in_fine)) |-> $stable(code));
  // R6
  valid_after_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(in_fine));
endmodule

// File: tb/two_step_therm_enc_test.sv
module two_step_therm_enc_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] coarse_therm = '0;
  logic [15:0] fine_therm = '0;
  logic [5:0]  grp_sel;
  logic [9:0]  code;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  two_step_therm_enc uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .coarse_therm (coarse_therm),
    .fine_therm   (fine_therm),
    .grp_sel      (grp_sel),
    .code         (code),
    .valid        (valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expect_val(logic [63:0] v, int w);
    for (int i = w - 1; i >= 0; i--)
      if (v[i]) return (i + 1 > w - 1) ? w - 1 : i + 1;
    return 0;
  endfunction

  function automatic logic [63:0] fill(int k);
    logic [63:0] r = '0;
    for (int i = 0; i < k; i++) r[i] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one conversion; disturbs coarse vector after it is sampled (R7)
  task automatic convert(string req, logic [63:0] c, logic [15:0] f);
    int ec, ef;
    ec = expect_val(c, 64);
    ef = expect_val({48'd0, f}, 16);
    @(negedge clk);
    coarse_therm = c; fine_therm = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check({req, " grp_sel"}, grp_sel, ec);
    check("R6 no early valid", valid, 0);
    coarse_therm = ~c;
    @(negedge clk);
    check("R6 valid", valid, 1);
    check({req, " code"}, code, ec * 16 + ef);
    @(negedge clk);
    check("R6 valid one cycle", valid, 0);
    check("R7 code held", code, ec * 16 + ef);
    check("R7 sel held", grp_sel, ec);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid", valid, 0);
    check("R1 code", code, 0);
    check("R1 grp_sel", grp_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", valid, 0);
    check("R1 code after release", code, 0);
  endtask

  task automatic t_ramps();
    convert("R2", fill(0), 16'h0000);
    convert("R2", fill(1), 16'h0001);
    convert("R2", fill(37), 16'h00FF);
    convert("R2", fill(63), 16'h7FFF);
    convert("R3", fill(64), 16'hFFFF);
    convert("R4", fill(5), 16'h1FFF);
  endtask

  task automatic t_bubbles();
    convert("R5", 64'h0000_0F00_0000_00F7, 16'h0205);
    convert("R5", 64'h8000_0000_0000_0000, 16'h8000);
    convert("R5", 64'h0000_0000_0001_0000, 16'h0010);
  endtask

  task automatic t_restart();
    @(negedge clk);
    coarse_therm = fill(10); fine_therm = 16'h0003; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    // now in fine step: relaunch with new vectors
    coarse_therm = fill(50); fine_therm = 16'h03FF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 abandoned no valid", valid, 0);
    @(negedge clk);
    check("R8 new grp_sel", grp_sel, 50);
    check("R8 still no valid", valid, 0);
    @(negedge clk);
    check("R8 valid", valid, 1);
    check("R8 code", code, 50 * 16 + 10);
    @(negedge clk);
    check("R8 valid one cycle", valid, 0);
  endtask

  initial begin
    t_reset();
    t_ramps();
    t_bubbles();
    t_restart();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule